// File: doc/BRIEF.md
# Folded Second-Order Recursive Filter Datapath

This block filters a stream of 16-bit signed fixed-point samples through a second-order recursive section. Each accepted sample x forms an internal node w = 5·x + (0.3·s1 + 0.2·s2) and an output y = 0.7·w + (0.4·s1 + 0.6·s2), where s1 and s2 are the two delayed values of w. After each sample the delay line shifts: s2 takes the old s1, and s1 takes the new w.

The whole computation runs on one shared constant multiplier and one shared adder. The multiplier has two pipeline stages and the adder has one. A free-running six-cycle schedule drives both units. Products and sums that are consumed one cycle after they appear go over direct links between the units. The two values that must wait longer (the 0.3·s1 product and the 0.4·s1 product) are parked in a small register file. The upstream source offers samples with a valid/ready handshake. The block takes at most one sample per six-cycle period and marks each result with a one-cycle valid pulse. A period with no sample offered is a bubble: it leaves the filter state untouched and produces no result.

Top module: `iir2_folded`

## Requirements
- R1: A slot counter runs through slots 0 to 5 and wraps without stopping. in_ready is high only in slot 0. The first cycle after reset is released is slot 0, so in_ready is high in that cycle and then every sixth cycle.
- R2: A sample is taken only in a cycle where in_valid and in_ready are both high. A sample offered while in_ready is low is held by the source and is taken exactly once, in the next slot 0.
- R3: Coefficients are Q4.12 codes: 20480 (5), 1229 (0.3), 819 (0.2), 1638 (0.4), 2458 (0.6) and 2867 (0.7). The input is sign-extended to 18-bit Q3.15. Each product is rounded as (p + 2048) >>> 12 and wrapped to 18 bits. Every addition wraps to 18 bits, grouped as in w and y above.
- R4: The state update (s2 takes the old s1, s1 takes w) happens once for each accepted sample. A period with no accepted sample leaves both state values unchanged.
- R5: out_valid is a one-cycle pulse that rises exactly 9 cycles after the cycle in which its sample was taken, which is slot 3 of the following period. There is one pulse per accepted sample and none for a bubble period.
- R6: out_data is the low 16 bits of the 18-bit y, with no saturation. An input of 16'h8000 makes 5·x wrap in the 18-bit format, and the result follows that wrap.
- R7: A synchronous active-low reset clears both state values, the register file, the slot counter (to slot 0) and out_valid. A sample taken in flight before the reset gives no result. The next sample after the reset sees zero state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Source offers a sample |
| in_ready | output | 1 | Block takes the offered sample this cycle (slot 0) |
| in_data | input | 16 | Input sample, signed Q1.15 |
| out_valid | output | 1 | One-cycle strobe marking out_data |
| out_data | output | 16 | Filtered sample, signed Q1.15 (wrapped) |

## Verification
The hardest case to reach from the ports is when the block state and the schedule fall out of step. This covers bubble periods between samples, a sample held across several non-ready cycles, and a reset that arrives while a result is still inside the multiplier pipeline. The stimulus table varies the idle gap before each offer. Some gaps put the offer in the middle of a period, so it is held. Others span one or two whole periods, so bubbles occur. Others land exactly on slot 0. The bench runs a model of the arithmetic and compares every result against it, so a bubble that changed the state would show up as a mismatch in later outputs. A directed test then drops reset in the middle of a sample and checks that the lost result never appears and that the next impulse sees zero state.

// File: rtl/iir2_pkg.sv
// Shared constants and types for the folded second-order filter.
// Assumes a fixed six-slot schedule: one multiplier issue per slot.
package iir2_pkg;
    localparam int PERIOD    = 6;
    localparam int SLOT_W    = $clog2(PERIOD);
    localparam int MEM_DEPTH = 2;
    localparam int MEM_AW    = (MEM_DEPTH > 1) ? $clog2(MEM_DEPTH) : 1;

    typedef logic [SLOT_W-1:0] slot_t;
    typedef logic [MEM_AW-1:0] maddr_t;

    // Slot names follow the product issued to the multiplier in that slot.
    localparam slot_t S_B1      = slot_t'(0); // 0.3*s1; add A1+A2 of previous sample
    localparam slot_t S_B2      = slot_t'(1); // 0.2*s2; add A0+(A1+A2) of previous sample
    localparam slot_t S_C0      = slot_t'(2); // 5*x; park B1; capture previous y
    localparam slot_t S_A1      = slot_t'(3); // 0.4*s1; add B1+B2
    localparam slot_t S_A2      = slot_t'(4); // 0.6*s2; add C0+(B1+B2) -> w
    localparam slot_t S_A0      = slot_t'(5); // 0.7*w; park A1; shift state
    localparam slot_t SLOT_LAST = slot_t'(PERIOD - 1);

    localparam maddr_t MEM_B1 = maddr_t'(0);
    localparam maddr_t MEM_A1 = maddr_t'(1);
endpackage

// File: rtl/iir2_sched.sv
// Cyclic schedule controller: free-running slot counter plus period flags.
// Assumes the upstream source holds in_valid/in_data until in_ready.
// live marks the current period as carrying a sample; prev_live marks
// the period before it, whose tail operations run in slots 0..2.
module iir2_sched
    import iir2_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  in_valid,
    output slot_t slot,
    output logic  in_ready,
    output logic  fire,
    output logic  live,
    output logic  prev_live
);

    assign in_ready = (slot == S_B1);
    assign fire     = in_valid & in_ready;

    // Advance the slot counter every cycle, wrapping at the period end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot <= '0;
        end else if (slot == SLOT_LAST) begin
            slot <= '0;
        end else begin
            slot <= slot + 1'b1;
        end
    end

    // Record at each period start whether a sample entered and age the flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            live      <= 1'b0;
            prev_live <= 1'b0;
        end else if (in_ready) begin
            live      <= in_valid;
            prev_live <= live;
        end
    end

    assert_wrap_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (slot == SLOT_LAST) |=> (slot == S_B1));

    assert_ready_gap_R1: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |=> !in_ready);

endmodule

// File: rtl/iir2_cmul.sv
// Shared constant-coefficient multiplier, two pipeline stages, one issue
// per cycle. Operand is Q3.15 (IN_W bits); coefficient has C_FRAC
// fraction bits. The result is rounded half-up back to the operand format
// and wraps on overflow (no saturation).
module iir2_cmul #(
    parameter int IN_W   = 18,
    parameter int C_W    = 16,
    parameter int C_FRAC = 12
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic signed [IN_W-1:0] opnd,
    input  logic signed [C_W-1:0]  coef,
    output logic signed [IN_W-1:0] res
);
    localparam int P_W = IN_W + C_W;
    localparam logic signed [P_W-1:0] HALF = P_W'(1) <<< (C_FRAC - 1);

    logic signed [IN_W-1:0] opnd_q;
    logic signed [C_W-1:0]  coef_q;
    logic signed [P_W-1:0]  prod;
    logic signed [P_W-1:0]  rnd;

    // Stage 1: register the issued operand pair.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            opnd_q <= '0;
            coef_q <= '0;
        end else begin
            opnd_q <= opnd;
            coef_q <= coef;
        end
    end

    assign prod = P_W'(opnd_q) * P_W'(coef_q);
    assign rnd  = prod + HALF;

    // Stage 2: register the rounded, rescaled product.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res <= '0;
        end else begin
            res <= rnd[C_FRAC +: IN_W];
        end
    end

endmodule

// File: rtl/iir2_add.sv
// Shared adder, one register stage, one issue per cycle, wrapping sum.
module iir2_add #(
    parameter int W = 18
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic signed [W-1:0] a,
    input  logic signed [W-1:0] b,
    output logic signed [W-1:0] sum
);

    // Register the wrapped sum of the two issued operands.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sum <= '0;
        end else begin
            sum <= a + b;
        end
    end

endmodule

// File: rtl/iir2_regfile.sv
// Small register file for intermediates that outlive a direct link.
// One write port, one combinational read port; cleared by reset.
module iir2_regfile #(
    parameter int W     = 18,
    parameter int DEPTH = 2,
    parameter int AW    = 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);
    logic [W-1:0] mem [DEPTH];

    // Write the addressed entry; clear every entry on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/iir2_folded.sv
// Folded second-order recursive filter: one shared multiplier, one shared
// adder and a two-entry register file under a six-slot cyclic schedule.
// Assumes ACC_W >= DATA_W and that both share the same fraction width.
// Result of a sample taken in slot 0 leaves in slot 3 of the next period.
module iir2_folded
    import iir2_pkg::*;
#(
    parameter int DATA_W    = 16,
    parameter int ACC_W     = 18,
    parameter int COEF_W    = 16,
    parameter int COEF_FRAC = 12,
    parameter logic signed [COEF_W-1:0] K_C0 = 16'sd20480,
    parameter logic signed [COEF_W-1:0] K_B1 = 16'sd1229,
    parameter logic signed [COEF_W-1:0] K_B2 = 16'sd819,
    parameter logic signed [COEF_W-1:0] K_A1 = 16'sd1638,
    parameter logic signed [COEF_W-1:0] K_A2 = 16'sd2458,
    parameter logic signed [COEF_W-1:0] K_A0 = 16'sd2867
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DATA_W-1:0] in_data,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data
);
    localparam int EXT_W = ACC_W - DATA_W;

    slot_t slot;
    logic  fire, live, prev_live;

    logic        [DATA_W-1:0] x_q;
    logic signed [ACC_W-1:0]  x_ext;
    logic signed [ACC_W-1:0]  s1_q, s2_q;
    logic signed [ACC_W-1:0]  mul_a, mul_res;
    logic signed [COEF_W-1:0] mul_c;
    logic signed [ACC_W-1:0]  add_a, add_b, add_res;
    logic                     mem_we;
    maddr_t                   mem_waddr, mem_raddr;
    logic        [ACC_W-1:0]  mem_rdata;

    iir2_sched u_sched (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .slot      (slot),
        .in_ready  (in_ready),
        .fire      (fire),
        .live      (live),
        .prev_live (prev_live)
    );

    iir2_cmul #(.IN_W(ACC_W), .C_W(COEF_W), .C_FRAC(COEF_FRAC)) u_cmul (
        .clk   (clk),
        .rst_n (rst_n),
        .opnd  (mul_a),
        .coef  (mul_c),
        .res   (mul_res)
    );

    iir2_add #(.W(ACC_W)) u_add (
        .clk   (clk),
        .rst_n (rst_n),
        .a     (add_a),
        .b     (add_b),
        .sum   (add_res)
    );

    iir2_regfile #(.W(ACC_W), .DEPTH(MEM_DEPTH), .AW(MEM_AW)) u_mem (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (mem_we),
        .waddr (mem_waddr),
        .wdata (mul_res),
        .raddr (mem_raddr),
        .rdata (mem_rdata)
    );

    assign x_ext = {{EXT_W{x_q[DATA_W-1]}}, x_q};

    // Capture the accepted input sample for its slot-2 multiply.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            x_q <= '0;
        end else if (fire) begin
            x_q <= in_data;
        end
    end

    // Pick the multiplier operand and coefficient for this slot.
    always_comb begin
        unique case (slot)
            S_B1:    begin mul_a = s1_q;    mul_c = K_B1; end
            S_B2:    begin mul_a = s2_q;    mul_c = K_B2; end
            S_C0:    begin mul_a = x_ext;   mul_c = K_C0; end
            S_A1:    begin mul_a = s1_q;    mul_c = K_A1; end
            S_A2:    begin mul_a = s2_q;    mul_c = K_A2; end
            default: begin mul_a = add_res; mul_c = K_A0; end
        endcase
    end

    // Pick adder operands: parked product + fresh product, or fresh product + last sum.
    always_comb begin
        unique case (slot)
            S_B1, S_A1: begin add_a = $signed(mem_rdata); add_b = mul_res; end
            S_B2, S_A2: begin add_a = mul_res;            add_b = add_res; end
            default:    begin add_a = '0;                 add_b = '0;      end
        endcase
    end

    // Park B1 (ready in slot 2) and A1 (ready in slot 5); read them a cycle later.
    assign mem_we    = live & ((slot == S_C0) | (slot == S_A0));
    assign mem_waddr = (slot == S_C0) ? MEM_B1 : MEM_A1;
    assign mem_raddr = (slot == S_A1) ? MEM_B1 : MEM_A1;

    // Shift the delay line once per accepted sample, when w leaves the adder.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_q <= '0;
            s2_q <= '0;
        end else if (live && slot == S_A0) begin
            s1_q <= add_res;
            s2_q <= s1_q;
        end
    end

    // Capture y of the previous period's sample and raise its strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else if (slot == S_C0 && prev_live) begin
            out_valid <= 1'b1;
            out_data  <= add_res[DATA_W-1:0];
        end else begin
            out_valid <= 1'b0;
        end
    end

    assert_out_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);

    assert_out_slot_R5: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (slot == S_A1));

    assert_state_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (slot != S_A0) |=> ($stable(s1_q) && $stable(s2_q)));

    assert_state_shift_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(s2_q) |-> (s2_q == $past(s1_q)));

    assert_reset_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (!out_valid && slot == S_B1 && s1_q == '0 && s2_q == '0));

endmodule

// File: tb/sim_iir2_folded.sv
// Self-checking bench: table-driven sample stream with varied gaps,
// then directed corner and reset tests. Inputs change 1 time unit after
// a rising edge; outputs are sampled on the falling edge.
module sim_iir2_folded;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 12;
    localparam int WDOG_CYCLES = 20000;

    localparam logic [15:0] VEC_X [NVEC] = '{
        16'h0800, 16'h0000, 16'hF800, 16'h0400, 16'h0C00, 16'hFC00,
        16'h0100, 16'h0000, 16'h0000, 16'h1000, 16'hF000, 16'h0200
    };
    localparam int VEC_GAP [NVEC] = '{0, 0, 3, 5, 7, 1, 0, 13, 5, 2, 5, 0};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic [15:0] in_data = '0;
    logic in_ready, out_valid;
    logic [15:0] out_data;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = -1;
    int rcnt = 0;
    int n_sent = 0;
    int n_acc = 0;
    int n_out = 0;
    bit after_rst = 1'b0;
    logic signed [17:0] ms1 = '0;
    logic signed [17:0] ms2 = '0;
    logic [15:0] exp_q [$];
    int due_q [$];

    iir2_folded u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_data   (in_data),
        .out_valid (out_valid),
        .out_data  (out_data)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
        end
    endtask

    // Arithmetic model of one coefficient product per R3.
    function automatic logic signed [17:0] qmul(input logic signed [17:0] v, input int c);
        longint p;
        p = longint'(v) * longint'(c);
        p = (p + 64'sd2048) >>> 12;
        return p[17:0];
    endfunction

    // Model one accepted sample; returns the expected 16-bit output (R3, R4, R6).
    function automatic logic [15:0] model_step(input logic [15:0] x);
        logic signed [17:0] x18, t, w, u, y;
        x18 = {{2{x[15]}}, x};
        t = qmul(ms1, 1229) + qmul(ms2, 819);
        w = qmul(x18, 20480) + t;
        u = qmul(ms1, 1638) + qmul(ms2, 2458);
        y = qmul(w, 2867) + u;
        ms2 = ms1;
        ms1 = w;
        return y[15:0];
    endfunction

    // Per-cycle monitor: ready pattern, acceptance, output value and timing.
    always @(negedge clk) begin
        if (!rst_n) begin
            rcnt++;
            if (rcnt >= 2) chk(out_valid == 1'b0, "R7", "out_valid in reset", int'(out_valid), 0);
            cyc = -1;
            exp_q.delete();
            due_q.delete();
            ms1 = '0;
            ms2 = '0;
            after_rst = 1'b1;
        end else begin
            rcnt = 0;
            cyc++;
            chk(in_ready == ((cyc % 6) == 0), "R1", "in_ready slot", int'(in_ready),
                int'((cyc % 6) == 0));
            if (in_valid && in_ready) begin
                n_acc++;
                exp_q.push_back(model_step(in_data));
                due_q.push_back(cyc + 9);
            end
            if (out_valid) begin
                n_out++;
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R5", "unexpected out_valid", cyc, -1);
                end else begin
                    chk(due_q[0] == cyc, "R5", "output cycle", cyc, due_q[0]);
                    if (after_rst)
                        chk(out_data == exp_q[0], "R7", "first output after reset",
                            int'(out_data), int'(exp_q[0]));
                    else
                        chk(out_data == exp_q[0], "R3", "output value",
                            int'(out_data), int'(exp_q[0]));
                    after_rst = 1'b0;
                    void'(exp_q.pop_front());
                    void'(due_q.pop_front());
                end
            end else if (due_q.size() != 0 && due_q[0] <= cyc) begin
                chk(1'b0, "R5", "missing out_valid", cyc, due_q[0]);
                void'(exp_q.pop_front());
                void'(due_q.pop_front());
            end
        end
    end

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    // Offer one sample after a gap and hold it until taken (R2).
    task automatic send(input logic [15:0] x, input int gap);
        bit taken;
        step(gap);
        in_valid = 1'b1;
        in_data  = x;
        n_sent++;
        taken = 1'b0;
        while (!taken) begin
            taken = in_ready;
            step(1);
        end
        in_valid = 1'b0;
        in_data  = 16'hDEAD;
    endtask

    initial begin
        #(CLK_PERIOD * WDOG_CYCLES);
        n_fail++;
        $display("FAIL R1 watchdog expired: actual %0d expected %0d", cyc, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        step(4);
        chk(out_valid == 1'b0, "R7", "out_valid at reset", int'(out_valid), 0);
        chk(in_ready == 1'b1, "R1", "in_ready at reset slot", int'(in_ready), 1);
        rst_n = 1'b1;

        // Table walk: varied gaps give held offers, aligned offers and bubbles.
        for (int i = 0; i < NVEC; i++) send(VEC_X[i], VEC_GAP[i]);
        step(20);

        // R6: most negative input wraps 5*x; then the largest positive input.
        send(16'h8000, 0);
        send(16'h7FFF, 2);
        step(20);
        chk(n_acc == n_sent, "R2", "samples taken once each", n_acc, n_sent);
        chk(n_out == n_acc, "R5", "one strobe per sample", n_out, n_acc);
        chk(exp_q.size() == 0, "R5", "no pending results", exp_q.size(), 0);

        // R7: reset with a result in flight, then an impulse on cleared state.
        send(16'h0800, 0);
        send(16'h0400, 0);
        step(3);
        rst_n = 1'b0;
        step(3);
        rst_n = 1'b1;
        chk(in_ready == 1'b1, "R7", "slot 0 after reset", int'(in_ready), 1);
        send(16'h0800, 0);
        send(16'h0000, 0);
        send(16'h0000, 6);
        step(20);
        chk(exp_q.size() == 0, "R7", "no pending results after reset", exp_q.size(), 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule